// File: doc/BRIEF.md
# Display Power-Stage Sequencer

This block brings the four stages of a display output path up and down in a fixed order. The stages, in power-up order, are the pixel clock (stage 0), timing synchronisation (stage 1), the panel display signal (stage 2) and the backlight PWM (stage 3). Each stage has its own one-cycle enable strobe and disable strobe. A command is accepted only when the stage it depends on has reached the needed state, as shown by that stage's status bit. A command that arrives too early is dropped and a sticky order-error flag is set.

Each stage status bit follows its enable output through a two-flop synchroniser. This models the crossing into the pixel domain. A status bit therefore only changes once the stage has really switched. The display signal does not switch at once. It waits for a programmable number of start-of-frame pulses, both when it rises and when it falls. A per-stage watchdog counter raises a sticky timeout flag if a stage's status has not matched its commanded state within a bounded number of cycles. Sequencing goes on after a timeout.

Top module: `lcd_power_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `stage_en` and `stage_sts` read 0000, and `order_err` and `timeout_flag` read 0.
- R2: Each bit of `stage_sts` equals the matching bit of `stage_en` delayed by exactly two clock cycles.
- R3: An enable strobe is accepted only if the stage before it in power-up order (0→1→2→3) has its status bit at 1. Stage 0 has no such condition. When an enable strobe is accepted for stage 0, 1 or 3, that stage's enable goes to 1 on the sampling edge. An enable strobe that is not accepted leaves `stage_en` unchanged and sets `order_err`.
- R4: A disable strobe is accepted only if the stage that must go down before it has its status bit at 0. The power-down order is 2, 1, 0, 3, so stage 1 needs stage 2 down, stage 0 needs stage 1 down, and stage 3 needs stage 0 down. Stage 2 has no such condition. A disable strobe that is not accepted leaves `stage_en` unchanged and sets `order_err`.
- R5: A strobe acts only on the stage whose bit it carries. An accepted strobe leaves the enables of all other stages unchanged.
- R6: After an accepted enable of stage 2, `stage_en[2]` rises on the clock edge that samples the G-th `sof` pulse after the acceptance edge, where G is `guard_frames`. When G is 0, it rises on the edge that follows the acceptance edge.
- R7: After an accepted disable of stage 2, `stage_en[2]` falls after the same guard rule as in R6.
- R8: While stage 2 is waiting out its guard time, further enable or disable strobes for stage 2 are ignored and do not set `order_err`.
- R9: If a stage's commanded state differs from its status bit for TIMEOUT_CYC consecutive cycles, `timeout_flag` goes to 1 on the edge that ends the TIMEOUT_CYC-th such cycle. The pending transition still completes afterwards.
- R10: `order_err` and `timeout_flag` stay at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_stb | input | 4 | Per-stage enable command strobes, bit i = stage i |
| dis_stb | input | 4 | Per-stage disable command strobes, bit i = stage i |
| sof | input | 1 | Start-of-frame pulse used to count guard frames |
| guard_frames | input | GUARD_W | Guard time for stage 2, in frames |
| stage_en | output | 4 | Stage enable outputs |
| stage_sts | output | 4 | Synchronised stage status bits |
| order_err | output | 1 | Sticky: a command arrived out of order |
| timeout_flag | output | 1 | Sticky: a stage did not reach its state in time |

## Verification
The bench sweeps the guard time from 0 to 2 frames for both rising and falling of the display stage. The stage must switch exactly on the edge that samples the last counted frame pulse, so a design that counts one pulse too many or too few, or counts the accepting cycle, fails the sweep. It sends early strobes in both the power-up and the power-down direction. A design that checks the wrong neighbour, or that lets a stray strobe disturb other stages, would show a changed enable or a missing error. The timeout is checked one cycle before and on the exact cycle it is due, and the display stage must still come up afterwards.

// File: rtl/lcd_power_seq_pkg.sv
package lcd_power_seq_pkg;
  localparam int NSTAGE  = 4;
  localparam int ST_CLK  = 0;
  localparam int ST_SYNC = 1;
  localparam int ST_DISP = 2;
  localparam int ST_PWM  = 3;

  typedef logic [NSTAGE-1:0] stage_vec_t;

  // stage that must be active before stage s may be enabled
  function automatic int up_pred(input int s);
    return (s == ST_CLK) ? ST_CLK : s - 1;
  endfunction

  // stage that must be inactive before stage s may be disabled
  // power-down order: display, sync, clock, pwm
  function automatic int down_pred(input int s);
    case (s)
      ST_SYNC: return ST_DISP;
      ST_CLK:  return ST_SYNC;
      ST_PWM:  return ST_CLK;
      default: return ST_DISP;
    endcase
  endfunction
endpackage

// File: rtl/lcd_sts_sync.sv
module lcd_sts_sync #(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/lcd_guard_stage.sv
module lcd_guard_stage #(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_on,
  input  logic               go_off,
  input  logic               sof,
  input  logic [GUARD_W-1:0] guard,
  output logic               en,
  output logic               tgt,
  output logic               busy
);
  logic [GUARD_W-1:0] cnt;
  logic [GUARD_W:0]   nxt;

  assign nxt = {1'b0, cnt} + {{GUARD_W{1'b0}}, sof};

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      tgt  <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go_off) begin
        tgt  <= 1'b0;
        busy <= 1'b1;
        cnt  <= '0;
      end else if (go_on) begin
        tgt  <= 1'b1;
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (nxt >= {1'b0, guard}) begin
      en   <= tgt;
      busy <= 1'b0;
    end else begin
      cnt <= nxt[GUARD_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_stage_watch.sv
module lcd_stage_watch #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tgt,
  input  logic sts,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  logic          mism;

  assign mism = tgt ^ sts;

  always_ff @(posedge clk) begin
    if (rst || !mism) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign hit = mism && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/lcd_power_seq.sv
module lcd_power_seq
  import lcd_power_seq_pkg::*;
#(
  parameter int GUARD_W     = 4,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         en_stb,
  input  logic [3:0]         dis_stb,
  input  logic               sof,
  input  logic [GUARD_W-1:0] guard_frames,
  output logic [3:0]         stage_en,
  output logic [3:0]         stage_sts,
  output logic               order_err,
  output logic               timeout_flag
);
  stage_vec_t en_q, sts, tgt, up_ok, down_ok, up_acc, down_acc, hit;
  logic       disp_busy;
  logic       err_set;

  lcd_sts_sync #(.W(NSTAGE), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst(rst), .d(en_q), .q(sts)
  );

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == ST_CLK) begin : g_up_free
      assign up_ok[i] = 1'b1;
    end else begin : g_up_dep
      assign up_ok[i] = sts[up_pred(i)];
    end

    if (i == ST_DISP) begin : g_down_free
      assign down_ok[i] = 1'b1;
    end else begin : g_down_dep
      assign down_ok[i] = ~sts[down_pred(i)];
    end

    assign up_acc[i]   = en_stb[i] & up_ok[i];
    assign down_acc[i] = dis_stb[i] & down_ok[i];

    if (i == ST_DISP) begin : g_guarded
      lcd_guard_stage #(.GUARD_W(GUARD_W)) i_guard (
        .clk(clk), .rst(rst),
        .go_on(up_acc[i]), .go_off(down_acc[i]),
        .sof(sof), .guard(guard_frames),
        .en(en_q[i]), .tgt(tgt[i]), .busy(disp_busy)
      );
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)              en_q[i] <= 1'b0;
        else if (down_acc[i]) en_q[i] <= 1'b0;
        else if (up_acc[i])   en_q[i] <= 1'b1;
      end
      assign tgt[i] = en_q[i];
    end

    lcd_stage_watch #(.LIMIT(TIMEOUT_CYC)) i_watch (
      .clk(clk), .rst(rst), .tgt(tgt[i]), .sts(sts[i]), .hit(hit[i])
    );
  end

  assign err_set = |(en_stb & ~up_ok) | |(dis_stb & ~down_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      order_err    <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      if (err_set) order_err <= 1'b1;
      if (|hit)    timeout_flag <= 1'b1;
    end
  end

  assign stage_en  = en_q;
  assign stage_sts = sts;
endmodule

// File: rtl/lcd_power_seq_chk.sv
module lcd_power_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] stage_en,
  input logic [3:0] stage_sts,
  input logic       order_err,
  input logic       timeout_flag
);
  assert_sts_rise_R2: assert property (@(posedge clk) disable iff (rst)
    ((stage_sts & ~$past(stage_sts)) & ~$past(stage_en, 2)) == 4'b0);

  assert_sts_fall_R2: assert property (@(posedge clk) disable iff (rst)
    ((~stage_sts & $past(stage_sts)) & $past(stage_en, 2)) == 4'b0);

  assert_sync_after_clk_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_en[1]) |-> $past(stage_sts[0]));

  assert_pwm_after_disp_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_en[3]) |-> $past(stage_sts[2]));

  assert_sync_down_after_disp_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(stage_en[1]) |-> !$past(stage_sts[2]));

  assert_clk_down_after_sync_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(stage_en[0]) |-> !$past(stage_sts[1]));

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !$fell(order_err) && !$fell(timeout_flag));
endmodule

bind lcd_power_seq lcd_power_seq_chk i_chk (
  .clk(clk), .rst(rst), .stage_en(stage_en), .stage_sts(stage_sts),
  .order_err(order_err), .timeout_flag(timeout_flag)
);

// File: tb/test_lcd_power_seq.sv
module test_lcd_power_seq;
  localparam int GW  = 3;
  localparam int TMO = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    en_stb, dis_stb;
  logic          sof;
  logic [GW-1:0] guard_frames;
  logic [3:0]    stage_en, stage_sts;
  logic          order_err, timeout_flag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lcd_power_seq #(.GUARD_W(GW), .TIMEOUT_CYC(TMO), .SYNC_DEPTH(2)) i_lcd_power_seq (
    .clk(clk), .rst(rst), .en_stb(en_stb), .dis_stb(dis_stb), .sof(sof),
    .guard_frames(guard_frames), .stage_en(stage_en), .stage_sts(stage_sts),
    .order_err(order_err), .timeout_flag(timeout_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [3:0] on, input logic [3:0] off);
    en_stb = on; dis_stb = off;
    step();
    en_stb = '0; dis_stb = '0;
  endtask

  task automatic sof_pulse();
    sof = 1'b1;
    step();
    sof = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  // bring up stages 0..n-1 in order with guard 0
  task automatic bring_up(input int n);
    guard_frames = '0;
    for (int s = 0; s < n; s++) begin
      cmd(4'(1 << s), 4'b0);
      if (s == 2) step();
      step(); step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; en_stb = '0; dis_stb = '0; sof = 1'b0; guard_frames = '0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 en", int'(stage_en), 0);
    chk("R1 sts", int'(stage_sts), 0);
    chk("R1 err", int'(order_err), 0);
    chk("R1 tmo", int'(timeout_flag), 0);

    // R3 sync before clock is rejected
    cmd(4'b0010, 4'b0);
    chk("R3 early sync en", int'(stage_en), 0);
    chk("R3 early sync err", int'(order_err), 1);
    step(); step(); step();
    chk("R10 err sticky", int'(order_err), 1);
    do_reset();
    chk("R1 err cleared", int'(order_err), 0);

    // R2 status latency
    cmd(4'b0001, 4'b0);
    chk("R2 en now", int'(stage_en), 1);
    chk("R2 sts +0", int'(stage_sts), 0);
    step();
    chk("R2 sts +1", int'(stage_sts), 0);
    step();
    chk("R2 sts +2", int'(stage_sts), 1);
    cmd(4'b0010, 4'b0);
    chk("R3 sync accepted", int'(stage_en), 3);
    step(); step();
    chk("R2 sync sts", int'(stage_sts), 3);

    // R5 disable of idle display touches nothing else
    guard_frames = '0;
    cmd(4'b0, 4'b0100);
    step(); step();
    chk("R5 others kept", int'(stage_en), 3);
    chk("R5 no err", int'(order_err), 0);

    // R6 / R7 / R8 guard sweep
    for (int g = 0; g <= 2; g++) begin
      guard_frames = GW'(g);
      cmd(4'b0100, 4'b0);
      chk("R6 not at accept", int'(stage_en[2]), 0);
      if (g == 0) begin
        step();
        chk("R6 guard0 rise", int'(stage_en[2]), 1);
      end else begin
        for (int k = 1; k <= g; k++) begin
          if (g == 2 && k == 1) cmd(4'b0, 4'b0100);  // R8 ignored while waiting
          else step();
          chk("R6 waiting", int'(stage_en[2]), 0);
          sof_pulse();
          chk("R6 after sof", int'(stage_en[2]), (k == g) ? 1 : 0);
        end
      end
      step(); step();
      chk("R6 disp sts", int'(stage_sts), 7);
      chk("R8 no err", int'(order_err), 0);

      cmd(4'b0, 4'b0100);
      chk("R7 not at accept", int'(stage_en[2]), 1);
      if (g == 0) begin
        step();
        chk("R7 guard0 fall", int'(stage_en[2]), 0);
      end else begin
        for (int k = 1; k <= g; k++) begin
          if (g == 2 && k == 1) cmd(4'b0100, 4'b0);  // R8 ignored while waiting
          else step();
          chk("R7 waiting", int'(stage_en[2]), 1);
          sof_pulse();
          chk("R7 after sof", int'(stage_en[2]), (k == g) ? 0 : 1);
        end
      end
      step(); step();
      chk("R7 disp sts", int'(stage_sts), 3);
    end
    chk("R8 err clean", int'(order_err), 0);
    chk("R9 no tmo", int'(timeout_flag), 0);

    // R3 pwm without display
    cmd(4'b1000, 4'b0);
    chk("R3 early pwm en", int'(stage_en), 3);
    chk("R3 early pwm err", int'(order_err), 1);

    // full up and down sequence
    do_reset();
    bring_up(4);
    chk("R3 all up en", int'(stage_en), 15);
    chk("R3 all up sts", int'(stage_sts), 15);
    cmd(4'b0, 4'b0100); step(); step(); step();
    cmd(4'b0, 4'b0010); step(); step();
    cmd(4'b0, 4'b0001); step(); step();
    chk("R4 pwm still on", int'(stage_en), 8);
    cmd(4'b0, 4'b1000); step(); step();
    chk("R4 all down en", int'(stage_en), 0);
    chk("R4 all down sts", int'(stage_sts), 0);
    chk("R4 no err", int'(order_err), 0);

    // R4 early disables
    do_reset();
    bring_up(4);
    cmd(4'b0, 4'b0010);
    chk("R4 early sync down", int'(stage_en), 15);
    chk("R4 early sync err", int'(order_err), 1);
    do_reset();
    bring_up(2);
    cmd(4'b0, 4'b1000);
    chk("R4 early pwm down en", int'(stage_en), 3);
    chk("R4 early pwm down err", int'(order_err), 1);

    // R9 timeout, then sequence continues
    do_reset();
    bring_up(2);
    guard_frames = GW'(1);
    cmd(4'b0100, 4'b0);
    repeat (TMO - 1) step();
    chk("R9 before limit", int'(timeout_flag), 0);
    step();
    chk("R9 at limit", int'(timeout_flag), 1);
    sof_pulse();
    chk("R9 continues", int'(stage_en[2]), 1);
    step(); step();
    chk("R9 disp sts", int'(stage_sts), 7);
    chk("R10 tmo sticky", int'(timeout_flag), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule